// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a 32-bit in-order CPU core and carries out the state changes needed to take an exception and to return from one. The pipeline presents a one-cycle strobe with a small cause code and the program counter of the interrupted instruction. The block classifies the cause as normal, debug or unsupported. It computes the handler address, which is a base register plus the cause times 32, so every cause owns an aligned 32-byte slot. It saves the interrupted PC into the matching link register, updates the interrupt-enable bits, and one cycle later presents a registered redirect PC with a valid flag to the fetch unit.

Two return paths are also handled. A return-from-exception pulse restores the global enable from its normal save bit and redirects to the saved exception address. A return-from-breakpoint pulse does the same with the debug save bit and the breakpoint address. Software reaches the six control registers through a plain write port and a combinational read port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When exc_valid is high with a supported cause, redirect_valid is high in the next cycle and redirect_pc equals the selected base plus cause × 32. When no strobe, return pulse or unsupported cause is seen, redirect_valid is low in the following cycle.
- R2: Causes other than 0, 1 and 3 are normal exceptions. They save exc_pc into the exception-address register and vector from the normal base, or from the debug base when the remap bit (debug control bit 0) is 1.
- R3: Causes 1 and 3 are debug exceptions. They save exc_pc into the breakpoint-address register, leave the exception-address register unchanged, and always vector from the debug base.
- R4: On entry, the save bit of that class (normal: enable bit 1, debug: enable bit 2) becomes 1 if the global enable (bit 0) was 1. Otherwise it keeps its value. The save bit of the other class is not changed.
- R5: Every accepted exception entry clears the global enable bit 0.
- R6: Cause 0 is unsupported. It raises unhandled_err for one cycle in the next cycle, gives no redirect and changes no register.
- R7: eret_valid redirects to the exception-address register and loads the global enable from bit 1. bret_valid redirects to the breakpoint-address register and loads the global enable from bit 2.
- R8: Bits 7:0 of both base registers read as zero whatever is written.
- R9: Register addresses are 0 normal base, 1 debug base, 2 debug control, 3 interrupt enable, 4 exception address, 5 breakpoint address. All reset to zero, and unused addresses read zero.
- R10: A register write in the same cycle as an entry lands, except for the fields the entry updates, which take the entry's values. The vector uses the base value from before the write.
- R11: An exception strobe takes priority over both return pulses, and bret_valid takes priority over eret_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_cause | input | 3 | Exception cause code |
| exc_pc | input | 32 | PC of the interrupted instruction |
| eret_valid | input | 1 | Return-from-exception pulse |
| bret_valid | input | 1 | Return-from-breakpoint pulse |
| csr_we | input | 1 | Register write enable |
| csr_addr | input | 3 | Register address for read and write |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect request, registered |
| redirect_pc | output | 32 | Fetch redirect target, registered |
| unhandled_err | output | 1 | Unsupported cause seen, registered pulse |

## Verification
The bench builds the block with its default parameters: a 3-bit cause, 32-byte slots, eight-bit base alignment, causes 1 and 3 as debug and cause 0 as unsupported. With only eight codes, every cause is swept against both remap settings and both global-enable states, so each class's base choice, link register and save bit is covered by an arithmetic expectation. The same small configuration makes the collision cases practical: register writes on the entry cycle, simultaneous exception and return pulses, and an unsupported cause together with a return are each aimed at directly.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CSR_AW = 3;

  localparam logic [CSR_AW-1:0] CSR_NBASE = 3'd0;
  localparam logic [CSR_AW-1:0] CSR_DBASE = 3'd1;
  localparam logic [CSR_AW-1:0] CSR_DCTL  = 3'd2;
  localparam logic [CSR_AW-1:0] CSR_IEN   = 3'd3;
  localparam logic [CSR_AW-1:0] CSR_EADDR = 3'd4;
  localparam logic [CSR_AW-1:0] CSR_BADDR = 3'd5;

  localparam int IEN_GLB  = 0;
  localparam int IEN_NSAV = 1;
  localparam int IEN_DSAV = 2;
  localparam int DCTL_REMAP = 0;

  typedef enum logic [1:0] {
    EK_NONE   = 2'd0,
    EK_NORMAL = 2'd1,
    EK_DEBUG  = 2'd2,
    EK_BAD    = 2'd3
  } exc_kind_e;

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W = 3,
  parameter logic [(1<<CAUSE_W)-1:0] DEBUG_MASK     = 8'b0000_1010,
  parameter logic [(1<<CAUSE_W)-1:0] SUPPORTED_MASK = 8'b1111_1110
) (
  input  logic               strobe,
  input  logic [CAUSE_W-1:0] cause,
  output exc_kind_e          kind
);
  localparam int NUM_CAUSES = 1 << CAUSE_W;

  logic [NUM_CAUSES-1:0] hit;

  // one-hot decode of the cause code
  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_hit
    assign hit[g] = strobe && (cause == CAUSE_W'(g));
  end

  logic hit_dbg;
  logic hit_ok;
  assign hit_dbg = |(hit & DEBUG_MASK);
  assign hit_ok  = |(hit & SUPPORTED_MASK);

  always_comb begin
    if (!strobe)       kind = EK_NONE;
    else if (!hit_ok)  kind = EK_BAD;
    else if (hit_dbg)  kind = EK_DEBUG;
    else               kind = EK_NORMAL;
  end

  always_comb begin
    assert_decode_onehot_R6: assert ($onehot0(hit));
  end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc #(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 3,
  parameter int SLOT_SHIFT = 5
) (
  input  logic [XLEN-1:0]    norm_base,
  input  logic [XLEN-1:0]    dbg_base,
  input  logic               remap,
  input  logic               is_debug,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    vector
);
  localparam int PAD = XLEN - CAUSE_W - SLOT_SHIFT;

  // byte offset of the slot that belongs to a cause
  function automatic logic [XLEN-1:0] slot_offset(input logic [CAUSE_W-1:0] c);
    return {{PAD{1'b0}}, c, {SLOT_SHIFT{1'b0}}};
  endfunction

  // debug causes always use the debug base; normal ones follow remap
  function automatic logic [XLEN-1:0] pick_base(input logic [XLEN-1:0] nb,
                                                input logic [XLEN-1:0] db,
                                                input logic rm,
                                                input logic dbg);
    return (dbg || rm) ? db : nb;
  endfunction

  assign vector = pick_base(norm_base, dbg_base, remap, is_debug) + slot_offset(cause);

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BASE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CSR_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              entry_norm,
  input  logic              entry_dbg,
  input  logic [XLEN-1:0]   entry_pc,
  input  logic              ret_norm,
  input  logic              ret_dbg,
  output logic [XLEN-1:0]   norm_base,
  output logic [XLEN-1:0]   dbg_base,
  output logic              remap,
  output logic              ie,
  output logic              nsav,
  output logic              dsav,
  output logic [XLEN-1:0]   eaddr,
  output logic [XLEN-1:0]   baddr
);
  logic [XLEN-1:BASE_LSB] nbase_q, dbase_q;
  logic                   remap_q;
  logic                   ie_q, nsav_q, dsav_q;
  logic [XLEN-1:0]        eaddr_q, baddr_q;

  logic                   ie_n, nsav_n, dsav_n;
  logic [XLEN-1:0]        eaddr_n, baddr_n;

  logic wr_nbase, wr_dbase, wr_dctl, wr_ien, wr_eaddr, wr_baddr;
  assign wr_nbase = wr_en && (wr_addr == CSR_NBASE);
  assign wr_dbase = wr_en && (wr_addr == CSR_DBASE);
  assign wr_dctl  = wr_en && (wr_addr == CSR_DCTL);
  assign wr_ien   = wr_en && (wr_addr == CSR_IEN);
  assign wr_eaddr = wr_en && (wr_addr == CSR_EADDR);
  assign wr_baddr = wr_en && (wr_addr == CSR_BADDR);

  logic entry_any;
  assign entry_any = entry_norm || entry_dbg;

  // enable bits: software write first, then entry/return override
  always_comb begin
    ie_n   = ie_q;
    nsav_n = nsav_q;
    dsav_n = dsav_q;
    if (wr_ien) begin
      ie_n   = wr_data[IEN_GLB];
      nsav_n = wr_data[IEN_NSAV];
      dsav_n = wr_data[IEN_DSAV];
    end
    if (entry_any) begin
      ie_n = 1'b0;
      if (ie_q) begin
        if (entry_norm) nsav_n = 1'b1;
        else            dsav_n = 1'b1;
      end
    end else if (ret_dbg) begin
      ie_n = dsav_q;
    end else if (ret_norm) begin
      ie_n = nsav_q;
    end
  end

  always_comb begin
    eaddr_n = eaddr_q;
    baddr_n = baddr_q;
    if (wr_eaddr)   eaddr_n = wr_data;
    if (wr_baddr)   baddr_n = wr_data;
    if (entry_norm) eaddr_n = entry_pc;
    if (entry_dbg)  baddr_n = entry_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbase_q <= '0;
      dbase_q <= '0;
      remap_q <= 1'b0;
      ie_q    <= 1'b0;
      nsav_q  <= 1'b0;
      dsav_q  <= 1'b0;
      eaddr_q <= '0;
      baddr_q <= '0;
    end else begin
      if (wr_nbase) nbase_q <= wr_data[XLEN-1:BASE_LSB];
      if (wr_dbase) dbase_q <= wr_data[XLEN-1:BASE_LSB];
      if (wr_dctl)  remap_q <= wr_data[DCTL_REMAP];
      ie_q    <= ie_n;
      nsav_q  <= nsav_n;
      dsav_q  <= dsav_n;
      eaddr_q <= eaddr_n;
      baddr_q <= baddr_n;
    end
  end

  assign norm_base = {nbase_q, {BASE_LSB{1'b0}}};
  assign dbg_base  = {dbase_q, {BASE_LSB{1'b0}}};
  assign remap     = remap_q;
  assign ie        = ie_q;
  assign nsav      = nsav_q;
  assign dsav      = dsav_q;
  assign eaddr     = eaddr_q;
  assign baddr     = baddr_q;

  assert_ie_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_any |=> !ie_q);

  assert_eaddr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_norm |=> eaddr_q == $past(entry_pc));

  assert_baddr_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_dbg |=> (baddr_q == $past(entry_pc)) && $stable(eaddr_q));

  assert_nsav_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_norm && ie_q) |=> nsav_q);

  assert_dsav_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_dbg && ie_q) |=> dsav_q);

  assert_ret_norm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_norm |=> ie_q == $past(nsav_q));

  assert_ret_dbg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_dbg |=> ie_q == $past(dsav_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 3,
  parameter int SLOT_SHIFT = 5,
  parameter int BASE_LSB   = 8,
  parameter logic [(1<<CAUSE_W)-1:0] DEBUG_MASK     = 8'b0000_1010,
  parameter logic [(1<<CAUSE_W)-1:0] SUPPORTED_MASK = 8'b1111_1110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic               eret_valid,
  input  logic               bret_valid,
  input  logic               csr_we,
  input  logic [CSR_AW-1:0]  csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               unhandled_err
);
  exc_kind_e kind;

  exc_cause_decode #(
    .CAUSE_W(CAUSE_W),
    .DEBUG_MASK(DEBUG_MASK),
    .SUPPORTED_MASK(SUPPORTED_MASK)
  ) u_decode (
    .strobe(exc_valid),
    .cause(exc_cause),
    .kind(kind)
  );

  // named events for the state bank and the assertions
  logic entry_norm, entry_dbg, entry_any, entry_bad, ret_norm, ret_dbg;
  assign entry_norm = (kind == EK_NORMAL);
  assign entry_dbg  = (kind == EK_DEBUG);
  assign entry_any  = entry_norm || entry_dbg;
  assign entry_bad  = (kind == EK_BAD);
  assign ret_dbg    = bret_valid && !exc_valid;
  assign ret_norm   = eret_valid && !bret_valid && !exc_valid;

  logic [XLEN-1:0] norm_base, dbg_base, eaddr, baddr;
  logic            remap, ie, nsav, dsav;

  exc_csr_bank #(
    .XLEN(XLEN),
    .BASE_LSB(BASE_LSB)
  ) u_bank (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(csr_we),
    .wr_addr(csr_addr),
    .wr_data(csr_wdata),
    .entry_norm(entry_norm),
    .entry_dbg(entry_dbg),
    .entry_pc(exc_pc),
    .ret_norm(ret_norm),
    .ret_dbg(ret_dbg),
    .norm_base(norm_base),
    .dbg_base(dbg_base),
    .remap(remap),
    .ie(ie),
    .nsav(nsav),
    .dsav(dsav),
    .eaddr(eaddr),
    .baddr(baddr)
  );

  logic [XLEN-1:0] vector;

  exc_vector_calc #(
    .XLEN(XLEN),
    .CAUSE_W(CAUSE_W),
    .SLOT_SHIFT(SLOT_SHIFT)
  ) u_vector (
    .norm_base(norm_base),
    .dbg_base(dbg_base),
    .remap(remap),
    .is_debug(entry_dbg),
    .cause(exc_cause),
    .vector(vector)
  );

  logic            rv_q, err_q;
  logic [XLEN-1:0] rpc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= entry_bad;
      if (entry_any) begin
        rv_q  <= 1'b1;
        rpc_q <= vector;
      end else if (ret_dbg) begin
        rv_q  <= 1'b1;
        rpc_q <= baddr;
      end else if (ret_norm) begin
        rv_q  <= 1'b1;
        rpc_q <= eaddr;
      end else begin
        rv_q  <= 1'b0;
      end
    end
  end

  assign redirect_valid = rv_q;
  assign redirect_pc    = rpc_q;
  assign unhandled_err  = err_q;

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      CSR_NBASE: csr_rdata = norm_base;
      CSR_DBASE: csr_rdata = dbg_base;
      CSR_DCTL:  csr_rdata[DCTL_REMAP] = remap;
      CSR_IEN: begin
        csr_rdata[IEN_GLB]  = ie;
        csr_rdata[IEN_NSAV] = nsav;
        csr_rdata[IEN_DSAV] = dsav;
      end
      CSR_EADDR: csr_rdata = eaddr;
      CSR_BADDR: csr_rdata = baddr;
      default:   csr_rdata = '0;
    endcase
  end

  assert_entry_redirect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    entry_any |=> redirect_valid);

  assert_slot_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_any |=> redirect_pc[SLOT_SHIFT-1:0] == '0);

  assert_bad_no_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_bad |=> unhandled_err && !redirect_valid && $stable(eaddr) && $stable(baddr));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid || eret_valid || bret_valid) |=> !redirect_valid && !unhandled_err);

  assert_event_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_norm, entry_dbg, entry_bad, ret_norm, ret_dbg}));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/100ps
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [2:0]  exc_cause = '0;
  logic [31:0] exc_pc = '0;
  logic        eret_valid = 1'b0;
  logic        bret_valid = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic        unhandled_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_pc(exc_pc),
    .eret_valid(eret_valid), .bret_valid(bret_valid),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .unhandled_err(unhandled_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    exc_valid = 1'b0; eret_valid = 1'b0; bret_valid = 1'b0; csr_we = 1'b0;
  endtask

  // finish an operation whose inputs were set at the previous negedge
  task automatic fire();
    @(negedge clk);
    clr();
    #0.5;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    fire();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #0.5;
    d = csr_rdata;
  endtask

  task automatic take(input logic [2:0] c, input logic [31:0] pc);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = c; exc_pc = pc;
    fire();
  endtask

  function automatic bit is_dbg(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd3);
  endfunction

  localparam logic [31:0] NB_W = 32'h1234_56FF;
  localparam logic [31:0] DB_W = 32'hABCD_0177;
  localparam logic [31:0] NB   = 32'h1234_5600;
  localparam logic [31:0] DB   = 32'hABCD_0100;

  function automatic logic [31:0] exp_vec(input logic [2:0] c, input bit rm,
                                          input logic [31:0] nb, input logic [31:0] db);
    return ((is_dbg(c) || rm) ? db : nb) + 32'(c) * 32;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;

    // R9: reset values and map
    chk("R9 redirect_valid reset", 32'(redirect_valid), 0);
    chk("R9 unhandled reset", 32'(unhandled_err), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R9 reset read", d, 0);
    end

    // R8: base low bits
    wr(3'd0, NB_W); rd(3'd0, d); chk("R8 normal base low bits", d, NB);
    wr(3'd1, DB_W); rd(3'd1, d); chk("R8 debug base low bits", d, DB);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, d); chk("R9 unused address", d, 0);

    // R1..R6: sweep every cause, remap and global enable
    for (int rm = 0; rm < 2; rm++) begin
      for (int ge = 0; ge < 2; ge++) begin
        for (int c = 0; c < 8; c++) begin
          wr(3'd2, 32'(rm));
          wr(3'd3, 32'(ge));
          wr(3'd4, 32'h0);
          wr(3'd5, 32'h0);
          pc = 32'h4000_0000 + 32'((rm * 16 + ge * 8 + c) * 4);
          take(3'(c), pc);
          if (c == 0) begin
            chk("R6 unhandled pulse", 32'(unhandled_err), 1);
            chk("R6 no redirect", 32'(redirect_valid), 0);
            rd(3'd3, d); chk("R6 enable untouched", d, 32'(ge));
            rd(3'd4, d); chk("R6 eaddr untouched", d, 0);
            rd(3'd5, d); chk("R6 baddr untouched", d, 0);
          end else begin
            chk("R1 redirect valid", 32'(redirect_valid), 1);
            chk("R1 vector", redirect_pc, exp_vec(3'(c), rm[0], NB, DB));
            chk("R6 no error", 32'(unhandled_err), 0);
            rd(3'd3, d);
            chk("R5 enable cleared", 32'(d[0]), 0);
            if (is_dbg(3'(c))) begin
              chk("R4 debug save", 32'(d[2]), 32'(ge));
              chk("R4 normal save kept", 32'(d[1]), 0);
              rd(3'd5, d); chk("R3 baddr saved", d, pc);
              rd(3'd4, d); chk("R3 eaddr kept", d, 0);
            end else begin
              chk("R4 normal save", 32'(d[1]), 32'(ge));
              chk("R4 debug save kept", 32'(d[2]), 0);
              rd(3'd4, d); chk("R2 eaddr saved", d, pc);
              rd(3'd5, d); chk("R2 baddr kept", d, 0);
            end
            chk("R1 redirect drops", 32'(redirect_valid), 0);
          end
        end
      end
    end
    wr(3'd2, 32'h0);

    // R4: save bit holds when global enable was 0
    wr(3'd3, 32'h2);
    take(3'd5, 32'h50);
    rd(3'd3, d); chk("R4 save bit kept when IE=0", d, 32'h2);
    wr(3'd3, 32'h4);
    take(3'd1, 32'h54);
    rd(3'd3, d); chk("R4 debug save kept when IE=0", d, 32'h4);

    // R7: returns
    wr(3'd4, 32'h0000_0100);
    wr(3'd3, 32'h2);
    @(negedge clk); eret_valid = 1'b1; fire();
    chk("R7 eret valid", 32'(redirect_valid), 1);
    chk("R7 eret target", redirect_pc, 32'h100);
    rd(3'd3, d); chk("R7 eret enable restore", d, 32'h3);
    wr(3'd5, 32'h0000_0200);
    wr(3'd3, 32'h1);
    @(negedge clk); bret_valid = 1'b1; fire();
    chk("R7 bret target", redirect_pc, 32'h200);
    rd(3'd3, d); chk("R7 bret enable restore", d, 32'h0);

    // R10: collisions between writes and entry
    wr(3'd3, 32'h1);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 3'd4; exc_pc = 32'h3000;
    csr_we = 1'b1; csr_addr = 3'd3; csr_wdata = 32'h5;
    fire();
    rd(3'd3, d); chk("R10 enable write vs entry", d, 32'h6);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 3'd6; exc_pc = 32'h3100;
    csr_we = 1'b1; csr_addr = 3'd4; csr_wdata = 32'hDEAD_BEEF;
    fire();
    rd(3'd4, d); chk("R10 eaddr entry wins", d, 32'h3100);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 3'd2; exc_pc = 32'h3200;
    csr_we = 1'b1; csr_addr = 3'd0; csr_wdata = 32'h7700_0000;
    fire();
    chk("R10 vector uses old base", redirect_pc, NB + 32'd64);
    rd(3'd0, d); chk("R10 base write lands", d, 32'h7700_0000);

    // R11: priorities
    wr(3'd4, 32'h0000_0400);
    wr(3'd5, 32'h0000_0800);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 3'd5; exc_pc = 32'h3300;
    eret_valid = 1'b1; bret_valid = 1'b1;
    fire();
    chk("R11 exception beats returns", redirect_pc, 32'h7700_0000 + 32'd160);
    @(negedge clk); eret_valid = 1'b1; bret_valid = 1'b1; fire();
    chk("R11 bret beats eret", redirect_pc, 32'h800);
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 3'd0; eret_valid = 1'b1;
    fire();
    chk("R11 bad cause suppresses eret", 32'(redirect_valid), 0);
    chk("R6 error with eret", 32'(unhandled_err), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule